// File: doc/BRIEF.md
# Byte-to-Word Stream Packer

This block takes a packet stream that carries one 8-bit symbol per beat and repacks it into 32-bit beats of four symbols each. Packet boundaries come in as a first-byte flag and a last-byte flag. The packed side carries first-beat and last-beat flags, plus a two-bit count of the unused symbols in the closing beat. Both sides use a valid/ready handshake in which a beat moves only in a cycle where valid and ready are high together, so the ready latency is zero.

The earliest symbol of each word goes in the most significant byte lane. When a packet ends partway through a word, that word is sent at once. Its unused trailing lanes, which are always the low-order lanes, are zero-filled and counted in the empty field. Packets of any length from one byte upward pass through. The block sits between a byte-wide producer and a word-wide consumer. It adds one register stage to the word path.

Top module: `byte_word_packer`

## Requirements
- R1: Within an output word, symbol 0 of that word (the earliest received) sits in bits 31:24, symbol 1 in bits 23:16, symbol 2 in bits 15:8 and symbol 3 in bits 7:0.
- R2: `out_first` is 1 on the first output word of a packet and 0 on every other word.
- R3: `out_last` is 1 on the final word of a packet and 0 elsewhere. A byte flagged last closes its word at once, even when that word holds fewer than four symbols.
- R4: On a word with `out_last` = 1, `out_empty` equals 4 minus the number of symbols the word carries (a 17-byte packet ends with empty = 3, and the 17th byte sits in bits 31:24). On words without `out_last`, `out_empty` is 0.
- R5: Unused low-order lanes of a closing word are driven to zero.
- R6: `in_first`, `in_last` and `in_byte` have no effect in cycles where `in_valid` is 0. Idle cycles with random marker values produce no output word and do not alter packet contents.
- R7: A byte is taken only in a cycle where `in_valid` and `in_ready` are both 1. `in_ready` is 1 exactly when the output register is empty or is being drained in the same cycle. Every byte offered is eventually taken exactly once, under any pattern of stalls.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_word`, `out_first`, `out_last` and `out_empty` keep their values into the next cycle.
- R9: A one-byte packet yields a single word with `out_first` = 1, `out_last` = 1 and `out_empty` = 3.
- R10: After synchronous reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Byte side: beat offered |
| in_ready | output | 1 | Byte side: beat can be taken this cycle |
| in_byte | input | 8 | Byte side: symbol |
| in_first | input | 1 | Byte side: first byte of a packet |
| in_last | input | 1 | Byte side: last byte of a packet |
| out_valid | output | 1 | Word side: word offered |
| out_ready | input | 1 | Word side: consumer takes the word this cycle |
| out_word | output | 32 | Word side: four symbols, earliest in the high byte |
| out_first | output | 1 | Word side: first word of a packet |
| out_last | output | 1 | Word side: last word of a packet |
| out_empty | output | 2 | Word side: unused trailing symbols, meaningful with out_last |

## Verification
The hardest case to reach is a byte flagged last that arrives while a packed word is stalled in the output register. The partial word must wait for `in_ready` without losing its lanes, and the first-word flag must still be correct. The stimulus reaches this case by running through alternating phases of full, half and sparse consumer readiness. Packet lengths are random, with every remainder modulo four, and producer gaps are random. Directed packets of 1, 2, 3, 4, 5, 8 and 17 bytes pin down the remainder cases, the single-byte case and the 17-byte case.

// File: rtl/bwp_pkg.sv
package bwp_pkg;
    localparam int unsigned SYM_W   = 8;
    localparam int unsigned LANES   = 4;
    localparam int unsigned WORD_W  = SYM_W * LANES;
    localparam int unsigned CNT_W   = $clog2(LANES);
    localparam int unsigned EMPTY_W = $clog2(LANES);

    typedef logic [SYM_W-1:0]   sym_t;
    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [CNT_W-1:0]   cnt_t;
    typedef logic [EMPTY_W-1:0] empty_t;

    typedef struct packed {
        word_t  data;
        logic   first;
        logic   last;
        empty_t empty;
    } beat_t;

    // Low bit position of a lane; lane 0 is the most significant byte.
    function automatic int unsigned lane_lsb(input int unsigned lane);
        return (LANES - 1 - lane) * SYM_W;
    endfunction

    // Mask covering the trailing unused lanes given an empty count.
    function automatic word_t tail_mask(input empty_t n);
        word_t m;
        m = '0;
        for (int unsigned b = 0; b < WORD_W; b++) begin
            if (b < int'(n) * SYM_W) m[b] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/bwp_gather.sv
module bwp_gather
    import bwp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  take,
    input  sym_t  sym,
    input  logic  sym_first,
    input  logic  sym_last,
    output logic  emit,
    output beat_t word
);
    sym_t held_q [LANES-1];
    cnt_t fill_q;
    logic open_q;

    assign emit = take && (sym_last || (fill_q == cnt_t'(LANES - 1)));

    always_comb begin
        word.data = '0;
        for (int unsigned k = 0; k < LANES; k++) begin
            if (cnt_t'(k) < fill_q)
                word.data[lane_lsb(k) +: SYM_W] = held_q[k];
            else if (cnt_t'(k) == fill_q)
                word.data[lane_lsb(k) +: SYM_W] = sym;
        end
        word.first = open_q || (fill_q == '0 && sym_first);
        word.last  = sym_last;
        word.empty = empty_t'(LANES - 1) - empty_t'(fill_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q <= '0;
            open_q <= 1'b0;
            for (int unsigned k = 0; k < LANES - 1; k++) held_q[k] <= '0;
        end else if (take) begin
            if (emit) begin
                fill_q <= '0;
                open_q <= 1'b0;
            end else begin
                held_q[fill_q] <= sym;
                fill_q         <= fill_q + 1'b1;
                if (fill_q == '0) open_q <= sym_first;
            end
        end
    end

    AST_FILL_RESTART: assert property (@(posedge clk) disable iff (rst)
        emit |=> (fill_q == '0)) else $error("fill not restarted"); // R3
endmodule

// File: rtl/bwp_outreg.sv
module bwp_outreg
    import bwp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  beat_t beat_in,
    input  logic  drain,
    output logic  valid,
    output beat_t beat_q,
    output logic  free
);
    assign free = !valid || drain;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid  <= 1'b0;
            beat_q <= '0;
        end else if (load) begin
            valid  <= 1'b1;
            beat_q <= beat_in;
        end else if (drain) begin
            valid  <= 1'b0;
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (valid && !drain) |=> (valid && $stable(beat_q))) else $error("stalled beat changed"); // R8
    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
        (load |-> free)) else $error("load into busy register"); // R7
endmodule

// File: rtl/byte_word_packer.sv
module byte_word_packer
    import bwp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [SYM_W-1:0]   in_byte,
    input  logic               in_first,
    input  logic               in_last,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [WORD_W-1:0]  out_word,
    output logic               out_first,
    output logic               out_last,
    output logic [EMPTY_W-1:0] out_empty
);
    logic  take;
    logic  emit;
    logic  free;
    beat_t packed_w;
    beat_t held_w;

    assign in_ready = free;
    assign take     = in_valid && free;

    bwp_gather u_gather (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .sym       (in_byte),
        .sym_first (in_first),
        .sym_last  (in_last),
        .emit      (emit),
        .word      (packed_w)
    );

    bwp_outreg u_outreg (
        .clk     (clk),
        .rst     (rst),
        .load    (emit),
        .beat_in (packed_w),
        .drain   (out_ready),
        .valid   (out_valid),
        .beat_q  (held_w),
        .free    (free)
    );

    assign out_word  = held_w.data;
    assign out_first = held_w.first;
    assign out_last  = held_w.last;
    assign out_empty = held_w.empty;

    AST_MID_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |-> (out_empty == '0)) else $error("empty on middle word"); // R4
    AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_last) |-> ((out_word & tail_mask(out_empty)) == '0)) else $error("tail lanes not zero"); // R5
    AST_IDLE_NO_WORD: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !out_valid) |=> !out_valid) else $error("word from idle input"); // R6
endmodule

// File: tb/tb_byte_word_packer.sv
`timescale 1ns/1ps
module tb_byte_word_packer;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_ready, in_first, in_last;
    logic [7:0]  in_byte;
    logic        out_valid, out_ready, out_first, out_last;
    logic [31:0] out_word;
    logic [1:0]  out_empty;

    always #2.5 clk = ~clk;

    byte_word_packer dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
        .in_first(in_first), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
        .out_first(out_first), .out_last(out_last), .out_empty(out_empty)
    );

    int total = 0;
    int bad   = 0;

    logic [7:0]  s_byte[$];
    bit          s_first[$];
    bit          s_last[$];
    logic [31:0] e_word[$];
    bit          e_first[$];
    bit          e_last[$];
    logic [1:0]  e_empty[$];
    bit          e_one[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Expected words for one packet, computed from R1..R5 and R9.
    task automatic add_packet(input int len);
        logic [7:0] b[];
        int nw;
        b = new[len];
        for (int i = 0; i < len; i++) begin
            b[i] = 8'($urandom);
            s_byte.push_back(b[i]);
            s_first.push_back(i == 0);
            s_last.push_back(i == len - 1);
        end
        nw = (len + 3) / 4;
        for (int j = 0; j < nw; j++) begin
            logic [31:0] w;
            w = '0;
            for (int k = 0; k < 4; k++)
                if (4 * j + k < len) w[31 - 8 * k -: 8] = b[4 * j + k];
            e_word.push_back(w);
            e_first.push_back(j == 0);
            e_last.push_back(j == nw - 1);
            e_empty.push_back((j == nw - 1) ? 2'(4 * nw - len) : 2'd0);
            e_one.push_back(len == 1);
        end
    endtask

    int          si, got, cyc, rpct;
    bit          hold_pend;
    logic [31:0] h_word;
    logic        h_first, h_last;
    logic [1:0]  h_empty;
    bit          idle_word;

    initial begin
        void'($urandom(32'h00C0FFEE));
        add_packet(1);  add_packet(17); add_packet(4); add_packet(5);
        add_packet(8);  add_packet(3);  add_packet(2); add_packet(1);
        for (int p = 0; p < 40; p++) add_packet(1 + int'($urandom % 13));

        rst = 1'b1; in_valid = 1'b0; in_byte = '0; in_first = 1'b0;
        in_last = 1'b0; out_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R10", "out_valid after reset", 32'(out_valid), 32'd0);
        chk(in_ready == 1'b1,  "R10", "in_ready after reset",  32'(in_ready),  32'd1);
        rst = 1'b0;

        si = 0; got = 0; cyc = 0; hold_pend = 0;
        while (got < e_word.size() && cyc < 100000) begin
            @(negedge clk);
            cyc++;
            if (hold_pend) begin
                chk(out_valid && out_word == h_word && out_first == h_first &&
                    out_last == h_last && out_empty == h_empty,
                    "R8", "stalled word changed", out_word, h_word);
            end
            case ((cyc / 300) % 3)
                0:       rpct = 100;
                1:       rpct = 50;
                default: rpct = 15;
            endcase
            out_ready = (int'($urandom % 100) < rpct);
            if (si < s_byte.size() && ($urandom % 100) < 70) begin
                in_valid = 1'b1;
                in_byte  = s_byte[si];
                in_first = s_first[si];
                in_last  = s_last[si];
            end else begin
                // R6: random junk on idle cycles
                in_valid = 1'b0;
                in_byte  = 8'($urandom);
                in_first = 1'($urandom);
                in_last  = 1'($urandom);
            end
            #1;
            chk(in_ready == (!out_valid || out_ready), "R7", "in_ready rule",
                32'(in_ready), 32'(!out_valid || out_ready));
            if (in_valid && in_ready) si++;
            if (out_valid && out_ready) begin
                chk(out_word == e_word[got], "R1", "word lanes", out_word, e_word[got]);
                chk(out_first == e_first[got], "R2", "first flag", 32'(out_first), 32'(e_first[got]));
                chk(out_last == e_last[got], "R3", "last flag", 32'(out_last), 32'(e_last[got]));
                chk(out_empty == e_empty[got], "R4", "empty count", 32'(out_empty), 32'(e_empty[got]));
                if (e_last[got])
                    chk((out_word & ((32'd1 << (8 * out_empty)) - 1)) == 0, "R5",
                        "tail lanes", out_word, e_word[got]);
                if (e_one[got])
                    chk(out_first && out_last && out_empty == 2'd3, "R9", "one-byte packet",
                        {29'd0, out_first, out_empty}, 32'h7);
                got++;
            end
            hold_pend = out_valid && !out_ready;
            h_word = out_word; h_first = out_first; h_last = out_last; h_empty = out_empty;
        end
        chk(cyc < 100000, "R7", "watchdog", 32'(cyc), 32'd100000);
        chk(si == s_byte.size(), "R7", "bytes taken", 32'(si), 32'(s_byte.size()));
        chk(got == e_word.size(), "R3", "words seen", 32'(got), 32'(e_word.size()));

        // R6: idle input with markers toggling must not create words.
        idle_word = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            out_ready = 1'b1;
            in_valid  = 1'b0;
            in_byte   = 8'($urandom);
            in_first  = 1'($urandom);
            in_last   = 1'($urandom);
            #1;
            if (i > 1 && out_valid) idle_word = 1;
        end
        chk(!idle_word, "R6", "word during idle", 32'(idle_word), 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule